// File: doc/BRIEF.md
# Iterative Newton Square Root

This block computes an approximate square root of an unsigned integer operand. The answer comes back as a fixed-point number with `F` fractional bits. Internally it refines an estimate `c` with the Newton–Heron step `c <- (c + a/c) / 2`. Each quotient `a/c` comes from a bit-serial restoring divider that is reused by every step.

The first estimate is a power of two taken from the position of the leading one of the operand, so it always starts at or above the true root. The refinement ends in one of two ways:

- after at most `ITER` steps (12 by default), or
- earlier, once two successive estimates differ by less than `2^-r`. The exponent `r` is supplied with each request. An `r` of `F` or more asks for full convergence.

Early exit only saves work. The result is always held back until the fixed worst-case latency of `ITER*(W+2F+2)` cycles has passed. A caller therefore sees a constant-latency pipeline stage whatever the operand. A zero operand skips the divider entirely and returns zero at the same latency.

Top module: `newton_sqrt`

## Requirements
- R1: With `thr_exp >= F`, `root` read as `root / 2^F` lies within `2 * 2^-F` of the exact square root of `operand`, for every operand value.
- R2: With `thr_exp < F`, `root / 2^F` is at least `sqrt(operand) - 2 * 2^-F` and at most `sqrt(operand) + 2^-thr_exp + 2 * 2^-F`. A smaller exponent allows a coarser early stop.
- R3: An operand of zero yields `root == 0` exactly.
- R4: `done` is high for exactly one cycle. It rises after the clock edge that is `LAT = ITER*(W+2F+2)` edges after the edge that accepted `start`, for every operand and exponent.
- R5: A `start` seen while a request is in flight is ignored. The pending `done` keeps its timing, and its `root` belongs to the first request.
- R6: `root` keeps its previous value from one `done` until the next. It changes only in the cycle that `done` is high.
- R7: Out of reset, `done` is 0 and `root` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, accepted when no request is in flight |
| operand | input | W | Unsigned integer whose root is wanted |
| thr_exp | input | RBITS | Exponent `r` of the early-stop threshold `2^-r` |
| root | output | W/2+F+1 | Root estimate, unsigned with F fractional bits |
| done | output | 1 | One-cycle pulse marking a fresh `root` |

## Verification
The hardest condition to reach from the ports is an early stop that leaves a visibly coarser answer while the latency stays unchanged. That needs small exponents together with operands whose first estimates lie far from the root. The bench therefore sweeps every operand of an 8-bit configuration at full precision. It then walks a spread of operands across every smaller exponent, each time checking both the error bound and the exact `done` cycle. A separate request injects a second `start` in the middle of a run to show that it has no effect at the ports.

// File: rtl/newton_sqrt_pkg.sv
package newton_sqrt_pkg;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_RUN  = 2'd1,
    ENG_HOLD = 2'd2
  } eng_state_t;

endpackage

// File: rtl/newton_seed.sv
module newton_seed #(
  parameter int W  = 16,
  parameter int F  = 8,
  parameter int RW = W/2 + F + 1
) (
  input  logic [W-1:0]  a,
  output logic [RW-1:0] seed
);

  // leading-one position of a (0 when a is zero)
  function automatic int lead_one(input logic [W-1:0] v);
    int p;
    p = 0;
    for (int i = 0; i < W; i++) begin
      if (v[i]) p = i;
    end
    return p;
  endfunction

  // 2^ceil((m+1)/2) scaled by 2^F is never below the true root
  function automatic logic [RW-1:0] first_guess(input logic [W-1:0] v);
    int e;
    e = (lead_one(v) + 2) / 2;
    return RW'(1) << (e + F);
  endfunction

  assign seed = first_guess(a);

endmodule

// File: rtl/newton_divider.sv
module newton_divider #(
  parameter int DW = 32,
  parameter int VW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] dividend,
  input  logic [VW-1:0] divisor,
  output logic          busy,
  output logic          fin,
  output logic [DW-1:0] quotient
);

  localparam int CW = $clog2(DW + 1);

  logic [VW-1:0] rem_q;
  logic [DW-1:0] quo_q;
  logic [VW-1:0] dvs_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic          fin_q;

  // one restoring step: bring in the next dividend bit, try to subtract
  logic [VW:0]   shifted;
  logic [VW:0]   trial;
  logic          take;
  logic [VW-1:0] rem_next;

  assign shifted  = {rem_q, quo_q[DW-1]};
  assign trial    = shifted - {1'b0, dvs_q};
  assign take     = shifted >= {1'b0, dvs_q};
  assign rem_next = take ? trial[VW-1:0] : shifted[VW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (load) begin
        rem_q  <= '0;
        quo_q  <= dividend;
        dvs_q  <= divisor;
        cnt_q  <= CW'(DW);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= rem_next;
        quo_q <= {quo_q[DW-2:0], take};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          fin_q  <= 1'b1;
        end
      end
    end
  end

  assign busy     = busy_q;
  assign fin      = fin_q;
  assign quotient = quo_q;

  // R1: a launch never carries a zero divisor
  p_nonzero_divisor_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> divisor != '0);

  // R4: a division always runs its full length before finishing
  p_fin_after_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> $past(busy));

endmodule

// File: rtl/newton_timer.sv
module newton_timer #(
  parameter int LAT = 408
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  output logic busy,
  output logic deadline
);

  localparam int CW = $clog2(LAT + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  assign deadline = busy_q && (cnt_q == CW'(LAT));
  assign busy     = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (accept) begin
      cnt_q  <= CW'(1);
      busy_q <= 1'b1;
    end else if (deadline) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4: the count never runs past the fixed latency
  p_count_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> cnt_q <= CW'(LAT));

  // R5: no new request is taken while one is in flight
  p_no_accept_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !busy_q);

endmodule

// File: rtl/newton_sqrt.sv
module newton_sqrt
  import newton_sqrt_pkg::*;
#(
  parameter int W     = 16,
  parameter int F     = 8,
  parameter int ITER  = 12,
  parameter int RBITS = $clog2(F + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [W-1:0]     operand,
  input  logic [RBITS-1:0] thr_exp,
  output logic [W/2+F:0]   root,
  output logic             done
);

  localparam int RW  = W/2 + F + 1;
  localparam int DW  = W + 2*F;
  localparam int LAT = ITER * (DW + 2);
  localparam int IW  = $clog2(ITER + 1);

  // ---------------- arithmetic helpers ----------------
  function automatic logic [RW-1:0] halve_sum(input logic [RW-1:0] c,
                                              input logic [RW-1:0] q);
    logic [RW:0] s;
    s = {1'b0, c} + {1'b0, q};
    return s[RW:1];
  endfunction

  function automatic logic [RW-1:0] abs_gap(input logic [RW-1:0] x,
                                            input logic [RW-1:0] y);
    return (x >= y) ? (x - y) : (y - x);
  endfunction

  // threshold 2^-r in raw units; r >= F means "no change at all"
  function automatic logic [RW-1:0] thr_raw(input logic [RBITS-1:0] r);
    if (int'(r) >= F) return RW'(1);
    return RW'(1) << (F - int'(r));
  endfunction

  // ---------------- internal events ----------------
  logic            tmr_busy;
  logic            deadline;
  logic            accept;
  logic            zero_in;
  logic [RW-1:0]   seed;
  logic            div_load;
  logic            div_busy;
  logic            div_fin;
  logic [DW-1:0]   div_q;
  logic [DW-1:0]   div_dividend;
  logic [RW-1:0]   div_divisor;
  logic [RW-1:0]   quot;
  logic [RW-1:0]   c_next;
  logic            converged;
  logic            last_step;
  logic            step_done;
  logic            stop_now;

  logic [W-1:0]     a_q;
  logic [RBITS-1:0] r_q;
  logic [RW-1:0]    c_q;
  logic [IW-1:0]    iter_q;
  eng_state_t       eng_q;
  logic [RW-1:0]    root_q;
  logic             done_q;

  assign accept    = start && !tmr_busy;
  assign zero_in   = (operand == '0);
  assign quot      = div_q[RW-1:0];
  assign c_next    = halve_sum(c_q, quot);
  assign converged = abs_gap(c_next, c_q) < thr_raw(r_q);
  assign last_step = (iter_q == IW'(ITER - 1));
  assign step_done = (eng_q == ENG_RUN) && div_fin;
  assign stop_now  = converged || last_step;
  assign div_load  = (accept && !zero_in) || (step_done && !stop_now);

  assign div_dividend = accept ? {operand, {(2*F){1'b0}}} : {a_q, {(2*F){1'b0}}};
  assign div_divisor  = accept ? seed : c_next;

  // ---------------- sub-blocks ----------------
  newton_seed #(.W(W), .F(F), .RW(RW)) u_seed (
    .a    (operand),
    .seed (seed)
  );

  newton_divider #(.DW(DW), .VW(RW)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (div_load),
    .dividend (div_dividend),
    .divisor  (div_divisor),
    .busy     (div_busy),
    .fin      (div_fin),
    .quotient (div_q)
  );

  newton_timer #(.LAT(LAT)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .busy     (tmr_busy),
    .deadline (deadline)
  );

  // ---------------- iteration engine ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      r_q    <= '0;
      c_q    <= '0;
      iter_q <= '0;
      eng_q  <= ENG_IDLE;
    end else if (accept) begin
      a_q    <= operand;
      r_q    <= thr_exp;
      iter_q <= '0;
      c_q    <= zero_in ? '0 : seed;
      eng_q  <= zero_in ? ENG_HOLD : ENG_RUN;
    end else if (step_done) begin
      c_q    <= c_next;
      iter_q <= iter_q + 1'b1;
      if (stop_now) eng_q <= ENG_HOLD;
    end else if (deadline) begin
      eng_q <= ENG_IDLE;
    end
  end

  // ---------------- result release ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      root_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= deadline;
      if (deadline) root_q <= c_q;
    end
  end

  assign root = root_q;
  assign done = done_q;

  // ---------------- assertions ----------------
  // R1: the first estimate is never below the true root
  p_seed_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !zero_in) |->
      ((2*RW)'(seed) * (2*RW)'(seed)) >= (2*RW)'({operand, {(2*F){1'b0}}}));

  // R1: every quotient fits the estimate width
  p_quot_fits_r1: assert property (@(posedge clk) disable iff (!rst_n)
    div_fin |-> div_q[DW-1:RW] == '0);

  // R2: the step count never exceeds the cap
  p_iter_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    iter_q <= IW'(ITER));

  // R2: a fresh division is never launched over a running one
  p_div_no_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    div_load |-> !div_busy);

  // R3: a zero operand gives a zero root
  p_zero_root_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (deadline && a_q == '0) |=> root == '0);

  // R4: refinement has finished when the deadline arrives
  p_ready_at_deadline_r4: assert property (@(posedge clk) disable iff (!rst_n)
    deadline |-> eng_q == ENG_HOLD);

  // R4: done is a single-cycle pulse
  p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5: a start during a run leaves the captured operand alone
  p_ignore_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && tmr_busy) |=> $stable(a_q));

  // R6: root moves only together with done
  p_root_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(root) |-> done);

endmodule

// File: tb/test_newton_sqrt.sv
module test_newton_sqrt;

  localparam int CLK_PERIOD = 10;
  localparam int W     = 8;
  localparam int F     = 4;
  localparam int ITER  = 12;
  localparam int RBITS = $clog2(F + 1);
  localparam int RW    = W/2 + F + 1;
  localparam int LAT   = ITER * (W + 2*F + 2);
  localparam real LSB  = 1.0 / (1 << F);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [W-1:0]     operand = '0;
  logic [RBITS-1:0] thr_exp = '0;
  logic [RW-1:0]    root;
  logic             done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  newton_sqrt #(.W(W), .F(F), .ITER(ITER)) i_newton_sqrt (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .operand (operand),
    .thr_exp (thr_exp),
    .root    (root),
    .done    (done)
  );

  task automatic chk_int(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_root(input int av, input int rv);
    real s, got, lo, hi;
    string req;
    s   = $sqrt(real'(av));
    got = real'(root) * LSB;
    lo  = s - 2.0 * LSB;
    if (av == 0) begin
      chk_int(root == '0, "R3 zero operand", int'(root), 0);
      return;
    end
    if (rv >= F) begin
      hi  = s + 2.0 * LSB;
      req = "R1 full precision";
    end else begin
      hi  = s + 1.0 / real'(1 << rv) + 2.0 * LSB;
      req = "R2 early stop";
    end
    checks++;
    if (got < lo || got > hi) begin
      errors++;
      $display("FAIL %s a=%0d r=%0d actual=%f expected=[%f,%f]", req, av, rv, got, lo, hi);
    end
  endtask

  // one request; optional intruding start in the middle of the run
  task automatic run_op(input int av, input int rv, input bit intrude);
    int bad;
    logic [RW-1:0] prev;
    @(negedge clk);
    prev    = root;
    start   = 1'b1;
    operand = W'(av);
    thr_exp = RBITS'(rv);
    @(posedge clk);
    #1 start = 1'b0;
    bad = 0;
    for (int j = 1; j <= LAT; j++) begin
      @(posedge clk);
      #1;
      if (j == LAT - 1)
        chk_int(root == prev, "R6 root held", int'(root), int'(prev));
      if (done !== (j == LAT)) bad++;
      if (intrude && j == 40) begin
        start   = 1'b1;
        operand = W'(9);
        thr_exp = '0;
      end
      if (intrude && j == 41) start = 1'b0;
    end
    chk_int(bad == 0, intrude ? "R5 done timing with intruder" : "R4 done timing", bad, 0);
    chk_root(av, rv);
    @(posedge clk);
    #1 chk_int(done == 1'b0, "R4 done one cycle", int'(done), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk_int(done == 1'b0, "R7 reset done", int'(done), 0);
    chk_int(root == '0, "R7 reset root", int'(root), 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk_int(done == 1'b0, "R7 idle done", int'(done), 0);

    // full sweep at full precision (R1, R3, R4, R6)
    for (int a = 0; a < (1 << W); a++) run_op(a, F, 1'b0);
    // clamped exponent above F behaves as full precision (R1)
    run_op(255, (1 << RBITS) - 1, 1'b0);
    run_op(2, (1 << RBITS) - 1, 1'b0);
    // coarse thresholds over a spread of operands (R2)
    for (int r = 0; r < F; r++)
      for (int a = 1; a < (1 << W); a += 17) run_op(a, r, 1'b0);
    // intruding start while busy (R5)
    run_op(200, F, 1'b1);
    run_op(100, F, 1'b0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule